// File: doc/BRIEF.md
# Bidirectional Parallel Port Register Controller

This block holds the host-visible registers of a legacy printer port and drives its pins in two modes. In the standard forward-only mode the data lines always drive. In the byte-wide bidirectional mode a control bit turns the data lines around, so the host can also read a byte that the peripheral presents. A small register bus (3-bit address, one-cycle read and write strobes, 8-bit data) reaches five registers: the output data latch, a live status view of the peripheral inputs, the control register, a mode selector and a fixed identification byte.

On the port side the block drives the eight data lines with an output enable and four active-low control lines. The control lines are modelled as drive-low enables. The five peripheral inputs (busy, acknowledge, paper-empty, select, fault) and the data lines are brought into the clock domain through a synchronizer. The acknowledge line feeds an interrupt flag. In standard mode the flag tracks the line level. In the other modes the flag is set by a rising edge and is cleared by reading the status register. A timeout pulse from an external handshake engine sets a sticky status flag.

The reset input is asserted asynchronously and its release is synchronized to the clock. All register state holds its reset values until two clock edges after `rst_n` rises.

Top module: `pport_regs`

## Requirements
- R1: After reset the data latch is 0x00, the control register reads 0x00, the mode register reads 0x20 (byte mode 001 in bits 7:5), `irq` is 0 and all four drive-low enables are 0.
- R2: Control bits 0 to 3 set `stb_low`, `afd_low`, `init_low` and `slin_low`, in that order. A 1 means the line is pulled low. Control bits 7:6 always read 0.
- R3: Control bit 5 is the direction bit, and 1 means input. In mode 000 the effective direction is forced to output: `pd_oe` is 1 and control bit 5 reads 0. In any other mode `pd_oe` is the inverse of bit 5.
- R4: While the port is in output direction, `pd_out` carries the data latch and a read of the data register (address 0) returns the latch. While it is in input direction, that read returns the synchronized `pd_in`.
- R5: Reading the status register (address 1) returns {~busy, ack, paper-empty, select, fault, int-flag, 0, timeout}, from bit 7 down to bit 0, with the pins sampled through the synchronizer.
- R6: In mode 000 the int-flag (status bit 2) equals the synchronized acknowledge level.
- R7: In any mode other than 000, the int-flag is set by a rising edge of acknowledge and is cleared by a status read. If a set and a clear fall in the same cycle, the set wins.
- R8: `irq` equals the int-flag ANDed with control bit 4.
- R9: A `tmo_evt` pulse sets status bit 0. A status read clears it after returning its value, and a status write with bit 0 at 1 clears it. A status write with bit 0 at 0 leaves it unchanged. A new pulse wins over a clear in the same cycle.
- R10: A write to the mode register (address 3, field in bits 7:5, other bits read 0) takes effect only if the current mode or the requested mode is 000 or 001. Any other write is ignored.
- R11: The identification register (address 4) always reads 0x94, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle (side effects only) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| pd_in | input | 8 | Data lines as seen at the pins |
| pd_out | output | 8 | Data lines driven value |
| pd_oe | output | 1 | Data line output enable |
| stb_low | output | 1 | Strobe line pull-low enable |
| afd_low | output | 1 | Auto-feed line pull-low enable |
| init_low | output | 1 | Initialize line pull-low enable |
| slin_low | output | 1 | Select-in line pull-low enable |
| busy_in | input | 1 | Peripheral busy |
| ack_in | input | 1 | Peripheral acknowledge (idle high) |
| pe_in | input | 1 | Paper empty |
| sel_in | input | 1 | Peripheral selected |
| fault_in | input | 1 | Fault line (low means error) |
| tmo_evt | input | 1 | Handshake timeout pulse |
| irq | output | 1 | Interrupt output |

## Verification
The two functions that can fall in the same cycle are the int-flag being set by an acknowledge edge and the same flag being cleared by a status read. The bench raises acknowledge and places the status read strobe exactly on the edge at which the synchronized rising edge is registered. The read must return bit 2 as 0, and afterwards `irq` must be high and a second read must show bit 2 at 1. The timeout flag has the same set-against-clear ordering, and it is judged through single pulses combined with reads and writes.

// File: rtl/pport_pkg.sv
package pport_pkg;

  typedef enum logic [2:0] {
    PM_SPP  = 3'b000,
    PM_BYTE = 3'b001,
    PM_FIFO = 3'b010,
    PM_EXT  = 3'b011,
    PM_EPP  = 3'b100,
    PM_RSV  = 3'b101,
    PM_TEST = 3'b110,
    PM_CFG  = 3'b111
  } pmode_e;

  localparam int unsigned AW = 3;

  localparam logic [AW-1:0] RA_DATA = 3'd0;
  localparam logic [AW-1:0] RA_STAT = 3'd1;
  localparam logic [AW-1:0] RA_CTRL = 3'd2;
  localparam logic [AW-1:0] RA_MODE = 3'd3;
  localparam logic [AW-1:0] RA_CFG  = 3'd4;

  localparam pmode_e RESET_MODE = PM_BYTE;

endpackage

// File: rtl/pport_sync.sv
module pport_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/pport_ackirq.sv
module pport_ackirq (
  input  logic clk,
  input  logic rst_n,
  input  logic ack_s,
  input  logic edge_mode,
  input  logic clr,
  output logic flag
);

  logic ack_d;
  logic latch_q, latch_d;
  logic ack_rise;

  assign ack_rise = ack_s & ~ack_d;

  always_comb begin
    latch_d = latch_q;
    if (clr)                  latch_d = 1'b0;
    if (ack_rise && edge_mode) latch_d = 1'b1;  // set beats clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_d   <= 1'b1;
      latch_q <= 1'b0;
    end else begin
      ack_d   <= ack_s;
      latch_q <= latch_d;
    end
  end

  assign flag = edge_mode ? latch_q : ack_s;

  // R7: an edge seen in edge mode always leaves the latch set, even under a read
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_rise && edge_mode) |=> latch_q);

  // R7: the latch only rises after an acknowledge edge
  a_r7_rise_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(latch_q) |-> $past(ack_rise && edge_mode));

endmodule

// File: rtl/pport_hostregs.sv
module pport_hostregs
  import pport_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [7:0]    wdata,
  input  logic          tmo_evt,
  output logic [DW-1:0] data_q,
  output logic [5:0]    ctrl_q,
  output pmode_e        mode_q,
  output logic          tmo_q
);

  logic   data_en, ctrl_en, mode_en;
  logic   stat_rd, stat_wr;
  logic   tmo_d;
  pmode_e mode_req;
  logic   mode_ok;

  assign data_en  = wr && (addr == RA_DATA);
  assign ctrl_en  = wr && (addr == RA_CTRL);
  assign stat_rd  = rd && (addr == RA_STAT);
  assign stat_wr  = wr && (addr == RA_STAT);
  assign mode_req = pmode_e'(wdata[7:5]);
  assign mode_ok  = (mode_q == PM_SPP) || (mode_q == PM_BYTE) ||
                    (mode_req == PM_SPP) || (mode_req == PM_BYTE);
  assign mode_en  = wr && (addr == RA_MODE) && mode_ok;

  always_comb begin
    tmo_d = tmo_q;
    if (stat_rd || (stat_wr && wdata[0])) tmo_d = 1'b0;
    if (tmo_evt)                          tmo_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctrl_q <= '0;
      mode_q <= RESET_MODE;
      tmo_q  <= 1'b0;
    end else begin
      if (data_en) data_q <= wdata[DW-1:0];
      if (ctrl_en) ctrl_q <= wdata[5:0];
      if (mode_en) mode_q <= mode_req;
      tmo_q <= tmo_d;
    end
  end

  // R10: leaving an extended mode only towards 000/001, entering only from them
  a_r10_mode_path: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |->
      ($past(mode_q) inside {PM_SPP, PM_BYTE} || mode_q inside {PM_SPP, PM_BYTE}));

  // R9: the timeout flag only rises after a timeout pulse
  a_r9_tmo_src: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tmo_q) |-> $past(tmo_evt));

endmodule

// File: rtl/pport_regs.sv
module pport_regs
  import pport_pkg::*;
#(
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [7:0]  CFG_ID      = 8'h94
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic [DW-1:0] pd_in,
  output logic [DW-1:0] pd_out,
  output logic          pd_oe,
  output logic          stb_low,
  output logic          afd_low,
  output logic          init_low,
  output logic          slin_low,
  input  logic          busy_in,
  input  logic          ack_in,
  input  logic          pe_in,
  input  logic          sel_in,
  input  logic          fault_in,
  input  logic          tmo_evt,
  output logic          irq
);

  localparam int unsigned NSTS = 5;
  localparam logic [NSTS-1:0] STS_RST = 5'b01000;  // acknowledge idles high

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_i_n = rst_q[1];

  logic [NSTS-1:0] sts_s;
  logic [DW-1:0]   pd_s;
  logic            busy_s, ack_s, pe_s, sel_s, fault_s;

  pport_sync #(.W(NSTS), .STAGES(SYNC_STAGES), .RST_VAL(STS_RST)) u_sts_sync (
    .clk(clk), .rst_n(rst_i_n),
    .d({busy_in, ack_in, pe_in, sel_in, fault_in}), .q(sts_s));

  pport_sync #(.W(DW), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pd_sync (
    .clk(clk), .rst_n(rst_i_n), .d(pd_in), .q(pd_s));

  assign {busy_s, ack_s, pe_s, sel_s, fault_s} = sts_s;

  logic [DW-1:0] data_q;
  logic [5:0]    ctrl_q;
  pmode_e        mode_q;
  logic          tmo_q;

  pport_hostregs #(.DW(DW)) u_hostregs (
    .clk(clk), .rst_n(rst_i_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .tmo_evt(tmo_evt),
    .data_q(data_q), .ctrl_q(ctrl_q), .mode_q(mode_q), .tmo_q(tmo_q));

  logic int_flag;
  logic stat_rd;
  logic edge_mode;
  logic dir_eff;
  logic ien;

  assign stat_rd   = bus_rd && (bus_addr == RA_STAT);
  assign edge_mode = (mode_q != PM_SPP);
  assign dir_eff   = edge_mode && ctrl_q[5];
  assign ien       = ctrl_q[4];

  pport_ackirq u_ackirq (
    .clk(clk), .rst_n(rst_i_n), .ack_s(ack_s), .edge_mode(edge_mode),
    .clr(stat_rd), .flag(int_flag));

  assign pd_out   = data_q;
  assign pd_oe    = ~dir_eff;
  assign stb_low  = ctrl_q[0];
  assign afd_low  = ctrl_q[1];
  assign init_low = ctrl_q[2];
  assign slin_low = ctrl_q[3];
  assign irq      = ien & int_flag;

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      RA_DATA: bus_rdata = dir_eff ? pd_s : data_q;
      RA_STAT: bus_rdata = {~busy_s, ack_s, pe_s, sel_s, fault_s, int_flag, 1'b0, tmo_q};
      RA_CTRL: bus_rdata = {2'b00, dir_eff, ctrl_q[4:0]};
      RA_MODE: bus_rdata = {mode_q, 5'b0_0000};
      RA_CFG:  bus_rdata = CFG_ID;
      default: bus_rdata = '0;
    endcase
  end

  // R3: standard mode never turns the data lines around
  a_r3_spp_drives: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mode_q == PM_SPP) |-> pd_oe);

  // R8: no interrupt while the enable bit is clear
  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_i_n)
    irq |-> ctrl_q[4]);

  // R2: control readback upper bits stay zero
  a_r2_ctrl_upper: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_addr == RA_CTRL) |-> (bus_rdata[7:6] == 2'b00));

  // R11: identification byte is fixed
  a_r11_cfg_fixed: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_addr == RA_CFG) |-> (bus_rdata == CFG_ID));

endmodule

// File: tb/pport_regs_bench.sv
module pport_regs_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] bus_addr;
  logic       bus_wr, bus_rd;
  logic [7:0] bus_wdata, bus_rdata;
  logic [7:0] pd_in, pd_out;
  logic       pd_oe, stb_low, afd_low, init_low, slin_low;
  logic       busy_in, ack_in, pe_in, sel_in, fault_in, tmo_evt, irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  pport_regs u_pport_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pd_in(pd_in), .pd_out(pd_out),
    .pd_oe(pd_oe), .stb_low(stb_low), .afd_low(afd_low), .init_low(init_low),
    .slin_low(slin_low), .busy_in(busy_in), .ack_in(ack_in), .pe_in(pe_in),
    .sel_in(sel_in), .fault_in(fault_in), .tmo_evt(tmo_evt), .irq(irq));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse_tmo();
    tmo_evt = 1'b1;
    @(negedge clk);
    tmo_evt = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd(3'd0, v); chk("R1 data", v, 8'h00);
    rd(3'd2, v); chk("R1 ctrl", v, 8'h00);
    rd(3'd3, v); chk("R1 mode", v, 8'h20);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 low enables", {4'd0, stb_low, afd_low, init_low, slin_low}, 8'h00);
  endtask

  task automatic t_cfg();
    logic [7:0] v;
    rd(3'd4, v); chk("R11 id", v, 8'h94);
    wr(3'd4, 8'h00);
    rd(3'd4, v); chk("R11 id after write", v, 8'h94);
  endtask

  task automatic t_ctrl();
    logic [7:0] v;
    wr(3'd2, 8'h0F);
    chk("R2 all low", {4'd0, stb_low, afd_low, init_low, slin_low}, 8'h0F);
    wr(3'd2, 8'hCA);
    rd(3'd2, v); chk("R2 readback", v, 8'h0A);
    chk("R2 pattern", {4'd0, stb_low, afd_low, init_low, slin_low}, 8'h05);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_dir();
    logic [7:0] v;
    wr(3'd0, 8'h5A);
    chk("R4 pd_out", pd_out, 8'h5A);
    chk("R3 oe byte out", {7'd0, pd_oe}, 8'h01);
    wr(3'd2, 8'h20);
    chk("R3 oe byte in", {7'd0, pd_oe}, 8'h00);
    pd_in = 8'hC3;
    idle(4);
    rd(3'd0, v); chk("R4 read pins", v, 8'hC3);
    wr(3'd3, 8'h00);
    chk("R3 spp forces out", {7'd0, pd_oe}, 8'h01);
    rd(3'd2, v); chk("R3 dir reads 0", v, 8'h00);
    rd(3'd0, v); chk("R4 read latch", v, 8'h5A);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] v;
    busy_in = 1; ack_in = 1; pe_in = 1; sel_in = 0; fault_in = 1;
    idle(4);
    rd(3'd1, v); chk("R5 status a", v, 8'h6C);
    busy_in = 0; sel_in = 1;
    idle(4);
    rd(3'd1, v); chk("R5 status b", v, 8'hFC);
    pe_in = 0;
  endtask

  task automatic t_spp_irq();
    logic [7:0] v;
    wr(3'd2, 8'h10);
    ack_in = 0; idle(4);
    rd(3'd1, v); chk("R6 flag low", {7'd0, v[2]}, 8'h00);
    chk("R8 irq low", {7'd0, irq}, 8'h00);
    ack_in = 1; idle(4);
    rd(3'd1, v); chk("R6 flag high", {7'd0, v[2]}, 8'h01);
    chk("R8 irq follows", {7'd0, irq}, 8'h01);
    wr(3'd2, 8'h00);
    chk("R8 irq masked", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_ps2_irq();
    logic [7:0] v;
    wr(3'd3, 8'h20);
    wr(3'd2, 8'h10);
    chk("R7 idle", {7'd0, irq}, 8'h00);
    ack_in = 0; idle(4);
    chk("R7 no set on fall", {7'd0, irq}, 8'h00);
    ack_in = 1; idle(4);
    chk("R7 set on rise", {7'd0, irq}, 8'h01);
    rd(3'd1, v); chk("R7 read shows flag", {7'd0, v[2]}, 8'h01);
    chk("R7 cleared by read", {7'd0, irq}, 8'h00);
    rd(3'd1, v); chk("R7 second read", {7'd0, v[2]}, 8'h00);
    // collision: edge registered on the same edge as the status read
    ack_in = 0; idle(4);
    ack_in = 1;
    @(negedge clk);
    @(negedge clk);
    rd(3'd1, v); chk("R7 collide read value", {7'd0, v[2]}, 8'h00);
    chk("R7 set wins irq", {7'd0, irq}, 8'h01);
    rd(3'd1, v); chk("R7 set wins flag", {7'd0, v[2]}, 8'h01);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_tmo();
    logic [7:0] v;
    pulse_tmo();
    rd(3'd1, v); chk("R9 set", {7'd0, v[0]}, 8'h01);
    rd(3'd1, v); chk("R9 clear by read", {7'd0, v[0]}, 8'h00);
    pulse_tmo();
    wr(3'd1, 8'h01);
    rd(3'd1, v); chk("R9 clear by write 1", {7'd0, v[0]}, 8'h00);
    pulse_tmo();
    wr(3'd1, 8'h00);
    rd(3'd1, v); chk("R9 write 0 keeps", {7'd0, v[0]}, 8'h01);
    rd(3'd1, v); chk("R9 then clear", {7'd0, v[0]}, 8'h00);
  endtask

  task automatic t_mode();
    logic [7:0] v;
    wr(3'd3, 8'h80); rd(3'd3, v); chk("R10 001 to 100", v, 8'h80);
    wr(3'd3, 8'h60); rd(3'd3, v); chk("R10 100 to 011 ignored", v, 8'h80);
    wr(3'd3, 8'h00); rd(3'd3, v); chk("R10 back to 000", v, 8'h00);
    wr(3'd3, 8'hC0); rd(3'd3, v); chk("R10 000 to 110", v, 8'hC0);
    wr(3'd3, 8'hA0); rd(3'd3, v); chk("R10 110 to 101 ignored", v, 8'hC0);
    wr(3'd3, 8'h3F); rd(3'd3, v); chk("R10 to 001 low bits zero", v, 8'h20);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; bus_addr = 0; bus_wr = 0; bus_rd = 0; bus_wdata = 0;
    pd_in = 0; busy_in = 0; ack_in = 1; pe_in = 0; sel_in = 1; fault_in = 1; tmo_evt = 0;
    idle(3);
    rst_n = 1;
    idle(4);
    t_reset();
    t_cfg();
    t_ctrl();
    t_dir();
    t_status();
    t_spp_irq();
    t_ps2_irq();
    t_tmo();
    t_mode();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule